// File: doc/BRIEF.md
# Two-Channel Staged DAC Code Loader

This block is the digital front end of a two-channel 12-bit digital-to-analog converter. It connects to an 8-bit microprocessor bus. Each channel has two registers. The first is a staging register that the processor fills one byte at a time: a low byte and a high nibble, in either order. The second is an output register that feeds the converter. A shared active-low transfer strobe copies both staging registers into the output registers in the same clock cycle. Software can therefore prepare both channels and then change both analog outputs together.

All bus inputs are sampled in the block's clock domain. The select, write and transfer strobes pass through a two-flop synchroniser. The address and data lines pass through a matching delay line, so that they stay aligned with the strobes. A write takes effect when the block sees the write cycle end, that is, when select or write returns high. While the transfer strobe is held low, the output registers follow the staging registers. When the strobe returns high, the output values are frozen.

Top module: `dual_dac_loader`

## Requirements
- R1: While `rstN` is low, both staging registers and both output registers are zero, and `chanAOut` and `chanBOut` read 0.
- R2: The bus address picks the staging part that is written. Address 0 is channel A bits 7..0, address 1 is channel A bits 11..8, address 2 is channel B bits 7..0, and address 3 is channel B bits 11..8.
- R3: A staging part is written only by a cycle in which both `busSelN` and `busWrN` are low. If either strobe stays high, no register and no output changes.
- R4: Data is right-justified. A high-part write takes bits 11..8 from `busData[3:0]` and ignores `busData[7:4]`. A low-part write takes all eight data bits.
- R5: The low and high parts of a channel may be written in either order, and the result is the same. Writing one part leaves the other part of that channel, and the other channel, unchanged.
- R6: While `xferN` is high, writes to the staging registers never change `chanAOut` or `chanBOut`.
- R7: While `xferN` is low, both output registers load from their staging registers in the same cycle. After `xferN` rises, the outputs hold their last loaded values.
- R8: `xferN` is independent of the write strobe. If `xferN` is held low across a write and stays low for at least three clock cycles after the write ends, the outputs end up showing the written value.
- R9: With `xferN` held low, an output shows a newly written value on the fourth rising clock edge after the write cycle ends, counting the first edge that samples the released strobe as the first. It does not show the value on the third edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all bus inputs are sampled on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| busSelN | input | 1 | Active-low chip select |
| busWrN | input | 1 | Active-low write strobe |
| busAddr | input | 2 | Staging part select (channel in bit 1, high part in bit 0) |
| busData | input | 8 | Right-justified data byte |
| xferN | input | 1 | Active-low shared transfer strobe |
| chanAOut | output | 12 | Channel A output register |
| chanBOut | output | 12 | Channel B output register |

## Verification
The checker watches every cycle for the following:
- The outputs read zero while reset is low.
- The outputs never move while the transfer strobe has been high long enough to pass the synchroniser.
- Any output change traces back to a low transfer strobe.
- A quiet bus with a steady low transfer strobe leaves the outputs still.

Only the bench scenarios can show the rest:
- Correct address decoding.
- Right-justified nibble placement.
- Either-order loading.
- The written value surviving an overlapped transfer.
- The exact commit latency.

These scenarios compare the outputs against a model of both register stages, driven by directed cases and by randomised write, null-write and transfer sequences.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
  // Strobes from control to datapath, one clock cycle each
  typedef struct packed {
    logic commit;    // write a staging part this cycle
    logic chanIdx;   // 0 = channel A, 1 = channel B
    logic highPart;  // 1 = upper bits of the staging register
    logic update;    // synchronised transfer strobe active
  } dacCtrl_t;
endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stage[0] <= RST_VAL;
    else       stage[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stage[i] <= RST_VAL;
      else       stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/dacfe_ctrl.sv
module dacfe_ctrl
  import dacfe_pkg::*;
#(
  parameter int BUS_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busSelN,
  input  logic             busWrN,
  input  logic [1:0]       busAddr,
  input  logic [BUS_W-1:0] busData,
  input  logic             xferN,
  output dacCtrl_t         ctrl,
  output logic [BUS_W-1:0] byteOut
);
  localparam int STROBE_W = 3;
  localparam int LANE_W = 2 + BUS_W;

  logic [STROBE_W-1:0] strobeSync;
  logic [LANE_W-1:0]   laneSync;
  logic                selS, wrS, xferS;
  logic [1:0]          addrS;
  logic [BUS_W-1:0]    dataS;
  logic                writeActive;
  logic                prevActive;
  logic [1:0]          prevAddr;
  logic [BUS_W-1:0]    prevData;

  dacfe_sync #(.W(STROBE_W), .STAGES(SYNC_STAGES), .RST_VAL({STROBE_W{1'b1}})) uStrobeSync (
    .clk(clk), .rstN(rstN), .d({busSelN, busWrN, xferN}), .q(strobeSync)
  );

  // Address and data follow the strobes through the same number of flops
  dacfe_sync #(.W(LANE_W), .STAGES(SYNC_STAGES), .RST_VAL({LANE_W{1'b0}})) uLaneAlign (
    .clk(clk), .rstN(rstN), .d({busAddr, busData}), .q(laneSync)
  );

  assign {selS, wrS, xferS} = strobeSync;
  assign {addrS, dataS} = laneSync;
  assign writeActive = !selS && !wrS;

  // Keep the last address and data seen while the write was active
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevActive <= 1'b0;
      prevAddr   <= '0;
      prevData   <= '0;
    end else begin
      prevActive <= writeActive;
      if (writeActive) begin
        prevAddr <= addrS;
        prevData <= dataS;
      end
    end
  end

  always_comb begin
    ctrl.commit   = prevActive && !writeActive;
    ctrl.chanIdx  = prevAddr[1];
    ctrl.highPart = prevAddr[0];
    ctrl.update   = !xferS;
    byteOut       = prevData;
  end
endmodule

// File: rtl/dacfe_datapath.sv
module dacfe_datapath
  import dacfe_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int BUS_W = 8,
  parameter int NUM_CH = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  dacCtrl_t                     ctrl,
  input  logic [BUS_W-1:0]             byteIn,
  output logic [NUM_CH-1:0][DATA_W-1:0] dacOut
);
  localparam int HI_W = DATA_W - BUS_W;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic [DATA_W-1:0] stageReg;
    logic [DATA_W-1:0] outReg;
    logic              hit;

    assign hit = ctrl.commit && (ctrl.chanIdx == 1'(ch));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stageReg <= '0;
      end else if (hit) begin
        if (ctrl.highPart) stageReg[DATA_W-1:BUS_W] <= byteIn[HI_W-1:0];
        else               stageReg[BUS_W-1:0]      <= byteIn;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            outReg <= '0;
      else if (ctrl.update) outReg <= stageReg;
    end

    assign dacOut[ch] = outReg;
  end
endmodule

// File: rtl/dual_dac_loader.sv
module dual_dac_loader
  import dacfe_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int BUS_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSelN,
  input  logic              busWrN,
  input  logic [1:0]        busAddr,
  input  logic [BUS_W-1:0]  busData,
  input  logic              xferN,
  output logic [DATA_W-1:0] chanAOut,
  output logic [DATA_W-1:0] chanBOut
);
  localparam int NUM_CH = 2;

  dacCtrl_t                      ctrl;
  logic [BUS_W-1:0]              byteBus;
  logic [NUM_CH-1:0][DATA_W-1:0] dacOut;

  dacfe_ctrl #(.BUS_W(BUS_W), .SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .busSelN(busSelN), .busWrN(busWrN),
    .busAddr(busAddr), .busData(busData), .xferN(xferN),
    .ctrl(ctrl), .byteOut(byteBus)
  );

  dacfe_datapath #(.DATA_W(DATA_W), .BUS_W(BUS_W), .NUM_CH(NUM_CH)) uData (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .byteIn(byteBus), .dacOut(dacOut)
  );

  assign chanAOut = dacOut[0];
  assign chanBOut = dacOut[1];
endmodule

// File: rtl/dual_dac_loader_chk.sv
module dual_dac_loader_chk #(
  parameter int DATA_W = 12,
  parameter int SYNC_STAGES = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSelN,
  input logic              busWrN,
  input logic              xferN,
  input logic [DATA_W-1:0] chanAOut,
  input logic [DATA_W-1:0] chanBOut
);
  localparam int HOLD_MIN = SYNC_STAGES + 1;
  localparam int CALM_MIN = SYNC_STAGES + 4;

  logic [7:0] sinceRst;
  logic [7:0] highCnt;
  logic [7:0] calmCnt;
  logic       xferPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceRst <= '0;
      highCnt  <= '0;
      calmCnt  <= '0;
      xferPrev <= 1'b1;
    end else begin
      xferPrev <= xferN;
      if (sinceRst != 8'hFF) sinceRst <= sinceRst + 8'd1;
      if (!xferN) highCnt <= '0;
      else if (highCnt != 8'hFF) highCnt <= highCnt + 8'd1;
      if ((!busSelN && !busWrN) || xferN) calmCnt <= '0;
      else if (calmCnt != 8'hFF) calmCnt <= calmCnt + 8'd1;
    end
  end

  always @(posedge clk) begin
    if (!rstN) begin
      AST_RESET_ZERO: assert (chanAOut == '0 && chanBOut == '0); // R1
    end
  end

  AST_HOLD_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (highCnt >= 8'(HOLD_MIN)) |-> ($stable(chanAOut) && $stable(chanBOut))); // R6

  AST_CHANGE_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 8'd4 && (!$stable(chanAOut) || !$stable(chanBOut))) |-> !$past(xferN, 3)); // R7

  AST_QUIET_BUS_STILL: assert property (@(posedge clk) disable iff (!rstN)
    (calmCnt >= 8'(CALM_MIN)) |-> ($stable(chanAOut) && $stable(chanBOut))); // R3
endmodule

bind dual_dac_loader dual_dac_loader_chk #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) uChk (
  .clk(clk), .rstN(rstN), .busSelN(busSelN), .busWrN(busWrN), .xferN(xferN),
  .chanAOut(chanAOut), .chanBOut(chanBOut)
);

// File: tb/tb_dual_dac_loader.sv
module tb_dual_dac_loader;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSelN = 1'b1;
  logic        busWrN = 1'b1;
  logic [1:0]  busAddr = '0;
  logic [7:0]  busData = '0;
  logic        xferN = 1'b1;
  logic [11:0] chanAOut, chanBOut;

  int total = 0;
  int bad = 0;
  logic [11:0] stA = '0, stB = '0, outA = '0, outB = '0;

  always #2 clk = ~clk;

  dual_dac_loader dut (
    .clk(clk), .rstN(rstN), .busSelN(busSelN), .busWrN(busWrN),
    .busAddr(busAddr), .busData(busData), .xferN(xferN),
    .chanAOut(chanAOut), .chanBOut(chanBOut)
  );

  function automatic logic [11:0] mergePart(logic [11:0] old, logic high, logic [7:0] b);
    logic [11:0] r = old;
    if (high) r[11:8] = b[3:0];
    else      r[7:0]  = b;
    return r;
  endfunction

  task automatic check(string tag, logic [11:0] expA, logic [11:0] expB);
    total++;
    if (chanAOut !== expA || chanBOut !== expB) begin
      bad++;
      $display("FAIL %s: actual A=%h B=%h expected A=%h B=%h", tag, chanAOut, chanBOut, expA, expB);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // One bus cycle; selOn/wrOn say which strobes go low
  task automatic busCycle(logic [1:0] a, logic [7:0] d, logic selOn, logic wrOn);
    @(negedge clk);
    busAddr = a; busData = d; busSelN = !selOn; busWrN = !wrOn;
    idle(3);
    busSelN = 1'b1; busWrN = 1'b1;
    if (selOn && wrOn) begin
      if (a[1]) stB = mergePart(stB, a[0], d);
      else      stA = mergePart(stA, a[0], d);
    end
    idle(6);
    if (!xferN) begin outA = stA; outB = stB; end
  endtask

  task automatic pulseXfer();
    @(negedge clk);
    xferN = 1'b0;
    idle(3);
    xferN = 1'b1;
    outA = stA; outB = stB;
    idle(5);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1C0FFEE));
    idle(4);
    check("R1 reset clears outputs", 12'h000, 12'h000);
    rstN = 1'b1;
    idle(2);

    // R2/R4/R6: writes with transfer high leave outputs alone
    busCycle(2'd0, 8'hAB, 1, 1);
    busCycle(2'd1, 8'h5C, 1, 1);
    check("R6 outputs hold while transfer high", 12'h000, 12'h000);
    pulseXfer();
    check("R2 R4 R7 channel A low byte and nibble", 12'hCAB, 12'h000);

    // R5: high part first on channel B
    busCycle(2'd3, 8'hF3, 1, 1);
    busCycle(2'd2, 8'h21, 1, 1);
    pulseXfer();
    check("R5 high-first order on channel B", 12'hCAB, 12'h321);
    busCycle(2'd0, 8'h00, 1, 1);
    pulseXfer();
    check("R5 other part and channel untouched", 12'hC00, 12'h321);

    // R3: strobes not both low
    busCycle(2'd2, 8'hEE, 0, 1);
    busCycle(2'd3, 8'hEE, 1, 0);
    busCycle(2'd0, 8'hEE, 0, 0);
    pulseXfer();
    check("R3 incomplete strobes ignored", 12'hC00, 12'h321);

    // R9: latency with transfer held low
    @(negedge clk);
    xferN = 1'b0;
    idle(4);
    busAddr = 2'd2; busData = 8'h77; busSelN = 1'b0; busWrN = 1'b0;
    idle(3);
    busWrN = 1'b1; busSelN = 1'b1;
    stB = mergePart(stB, 1'b0, 8'h77);
    repeat (3) @(posedge clk);
    #1 check("R9 not yet on third edge", 12'hC00, 12'h321);
    @(posedge clk);
    #1 check("R9 visible on fourth edge", 12'hC00, 12'h377);
    outB = stB;

    // R8: write overlapped by a low transfer strobe
    busCycle(2'd1, 8'h09, 1, 1);
    idle(13);
    xferN = 1'b1;
    idle(5);
    check("R8 overlapped write lands", 12'h900, 12'h377);
    busCycle(2'd0, 8'h55, 1, 1);
    check("R7 frozen after transfer rises", 12'h900, 12'h377);
    pulseXfer();
    check("R7 both channels loaded together", 12'h955, 12'h377);

    // Random mix
    for (int i = 0; i < 300; i++) begin
      int op = $urandom_range(0, 9);
      if (op < 5)      busCycle(2'($urandom), 8'($urandom), 1, 1);
      else if (op < 7) busCycle(2'($urandom), 8'($urandom), 1'($urandom), 1'b0 ^ 1'b0);
      else if (op < 9) pulseXfer();
      else begin
        @(negedge clk);
        xferN = !xferN;
        idle(6);
        if (!xferN) begin outA = stA; outB = stB; end
      end
      if (i % 10 == 9) check("R2 R4 R5 R6 R7 random sequence", outA, outB);
    end
    @(negedge clk);
    xferN = 1'b1;
    idle(4);
    pulseXfer();
    check("R7 final transfer", stA, stB);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule